// File: doc/BRIEF.md
# I2C Receive Byte Double Buffer

This block is the received-byte path of an I2C slave or master. Each completed byte is offered on a strobe together with its eight data bits. The block keeps two registers: a shift stage that catches the incoming byte, and a read stage that the host reads. A read-request flag tells the host that the read stage holds data it has not yet taken.

When the read stage is free, a new byte goes straight into it and the flag rises. When the host has not read yet, the byte waits in the shift stage and the read stage keeps its value. A host read then clears the flag and moves the waiting byte across in the same step, so the flag falls and rises at once.

In transmit mode nothing moves into the read stage. Turning the module off, or an internal initialize pulse, clears the flag and drops any waiting byte. Bit sampling, START/STOP detection, acknowledge and clock stretching belong to neighbouring logic.

Top module: `i2c_rx_dbuf`

## Requirements
- R1: After reset, `rd_req` is 0 and `rd_data` is 0x00.
- R2: In receive mode (`tx_mode`=0), with the module on and the flag at 0 and no byte waiting, a `byte_done` strobe makes `rd_data` equal `byte_data` and `rd_req` equal 1 on the next cycle.
- R3: A `host_rd` pulse with no byte waiting and no `byte_done` in the same cycle clears `rd_req` on the next cycle and leaves `rd_data` unchanged.
- R4: A `byte_done` while `rd_req` is 1 and no read is made leaves `rd_data` unchanged and `rd_req` at 1. The byte waits. A further such byte replaces the waiting one.
- R5: In receive mode, a `host_rd` while a byte waits makes `rd_data` equal the waiting byte and `rd_req` equal 1 on the next cycle.
- R6: A `host_rd` and a `byte_done` in the same receive-mode cycle with `rd_req`=1 and no byte waiting apply the read first. On the next cycle `rd_data` equals the new byte and `rd_req` is 1.
- R7: In transmit mode (`tx_mode`=1), `byte_done` has no effect and no byte moves into the read stage. `host_rd` still clears `rd_req`, and `rd_data` does not change.
- R8: While `enable` is 0, `rd_req` is 0 on the next cycle, any waiting byte is dropped, `byte_done` is ignored, and `rd_data` keeps its value.
- R9: An `init_pulse` has the same effect as R8 for that cycle.
- R10: A byte left waiting with `rd_req`=0 (after a transmit-mode read) moves into `rd_data` with `rd_req`=1 on the first receive-mode cycle with the module on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_done | input | 1 | One-cycle strobe: a byte has completed (9th clock rising edge) |
| byte_data | input | 8 | Byte value valid with `byte_done` |
| host_rd | input | 1 | One-cycle host read of the read stage |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| enable | input | 1 | Module enable; 0 clears the flag |
| init_pulse | input | 1 | Internal initialize pulse |
| rd_data | output | 8 | Read-stage data |
| rd_req | output | 1 | Read-request flag: unread data waiting |

## Verification
The assertions assume that `byte_done` and `host_rd` are single-cycle strobes sampled at the clock edge. They also assume that `enable`, `init_pulse` and `tx_mode` are synchronous levels that can change on any cycle. They assume nothing about how often bytes arrive, so back-to-back strobes and a strobe that coincides with a read are both legal. The stimulus drives every input just after the falling edge. It covers bursts with and without reads, reads made while a byte waits, coincident read and byte, mode flips while a byte waits, and disable or initialize pulses in the middle of a burst.

// File: rtl/i2c_rx_dbuf_pkg.sv
package i2c_rx_dbuf_pkg;

  localparam int unsigned BYTE_W = 8;

  // The flag as seen after this cycle's host read has been applied.
  function automatic logic flag_after_read(input logic flag, input logic rd);
    return flag & ~rd;
  endfunction

  // A waiting byte moves when the read stage is (or becomes) free.
  function automatic logic move_waiting(input logic rx, input logic waiting,
                                        input logic flag_eff);
    return rx & waiting & ~flag_eff;
  endfunction

  // A new byte goes straight into the read stage only if nothing is ahead of it.
  function automatic logic load_direct(input logic rx_byte, input logic waiting,
                                       input logic flag_eff);
    return rx_byte & ~waiting & ~flag_eff;
  endfunction

endpackage

// File: rtl/i2c_rx_shift_stage.sv
module i2c_rx_shift_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drop,
  input  logic         capture,
  input  logic         release_q,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      full <= 1'b0;
    end else if (drop) begin
      full <= 1'b0;
    end else if (capture) begin
      q    <= din;
      full <= 1'b1;
    end else if (release_q) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rx_read_stage.sv
module i2c_rx_read_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drop,
  input  logic         from_shift,
  input  logic         from_input,
  input  logic         host_rd,
  input  logic [W-1:0] shift_q,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (!drop) begin
      if (from_shift)      q <= shift_q;
      else if (from_input) q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag <= 1'b0;
    else if (drop)                    flag <= 1'b0;
    else if (from_shift | from_input) flag <= 1'b1;
    else if (host_rd)                 flag <= 1'b0;
  end
endmodule

// File: rtl/i2c_rx_dbuf.sv
module i2c_rx_dbuf
  import i2c_rx_dbuf_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_done,
  input  logic [W-1:0] byte_data,
  input  logic         host_rd,
  input  logic         tx_mode,
  input  logic         enable,
  input  logic         init_pulse,
  output logic [W-1:0] rd_data,
  output logic         rd_req
);
  // Named internal events, also used by the checker.
  logic         drop_ev;
  logic         rx_active;
  logic         flag_eff;
  logic         mv_held_ev;
  logic         ld_direct_ev;
  logic         capture_ev;
  logic         held;
  logic [W-1:0] shift_q;

  assign drop_ev      = ~enable | init_pulse;
  assign rx_active    = ~drop_ev & ~tx_mode;
  assign flag_eff     = flag_after_read(rd_req, host_rd);
  assign mv_held_ev   = move_waiting(rx_active, held, flag_eff);
  assign ld_direct_ev = load_direct(rx_active & byte_done, held, flag_eff);
  assign capture_ev   = rx_active & byte_done & ~ld_direct_ev;

  i2c_rx_shift_stage #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .drop      (drop_ev),
    .capture   (capture_ev),
    .release_q (mv_held_ev),
    .din       (byte_data),
    .q         (shift_q),
    .full      (held)
  );

  i2c_rx_read_stage #(.W(W)) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .drop       (drop_ev),
    .from_shift (mv_held_ev),
    .from_input (ld_direct_ev),
    .host_rd    (host_rd),
    .shift_q    (shift_q),
    .din        (byte_data),
    .q          (rd_data),
    .flag       (rd_req)
  );
endmodule

// File: rtl/i2c_rx_dbuf_chk.sv
module i2c_rx_dbuf_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         byte_done,
  input logic [W-1:0] byte_data,
  input logic         host_rd,
  input logic         tx_mode,
  input logic         enable,
  input logic         init_pulse,
  input logic [W-1:0] rd_data,
  input logic         rd_req,
  input logic         held,
  input logic [W-1:0] shift_q
);
  logic live;
  assign live = enable & ~init_pulse;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !rd_req);

  p_direct_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live && !tx_mode && byte_done && !rd_req && !held
    |=> rd_req && rd_data == $past(byte_data));

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live && host_rd && !held && !byte_done |=> !rd_req && $stable(rd_data));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live && !tx_mode && byte_done && rd_req && !host_rd
    |=> rd_req && held && $stable(rd_data));

  p_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && !tx_mode && host_rd && held
    |=> rd_req && rd_data == $past(shift_q));

  p_coincide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live && !tx_mode && host_rd && byte_done && rd_req && !held
    |=> rd_req && rd_data == $past(byte_data) && !held);

  p_tx_nomove_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live && tx_mode |=> $stable(rd_data));

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rd_req && !held && $stable(rd_data));

  p_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> !rd_req && !held && $stable(rd_data));

  p_late_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live && !tx_mode && held && !rd_req
    |=> rd_req && rd_data == $past(shift_q));
endmodule

bind i2c_rx_dbuf i2c_rx_dbuf_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_done  (byte_done),
  .byte_data  (byte_data),
  .host_rd    (host_rd),
  .tx_mode    (tx_mode),
  .enable     (enable),
  .init_pulse (init_pulse),
  .rd_data    (rd_data),
  .rd_req     (rd_req),
  .held       (held),
  .shift_q    (shift_q)
);

// File: tb/sim_i2c_rx_dbuf.sv
`timescale 1ns/1ps
module sim_i2c_rx_dbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_done = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       host_rd = 1'b0;
  logic       tx_mode = 1'b0;
  logic       enable = 1'b1;
  logic       init_pulse = 1'b0;
  logic [7:0] rd_data;
  logic       rd_req;

  int errors = 0;
  int checks = 0;

  // Reference model: a read slot and a queue of at most one waiting byte.
  logic [7:0] m_slot = 8'h00;
  bit         m_unread = 0;
  logic [7:0] m_wait[$];

  always #2 clk = ~clk;

  i2c_rx_dbuf u0 (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_data(byte_data),
    .host_rd(host_rd), .tx_mode(tx_mode), .enable(enable),
    .init_pulse(init_pulse), .rd_data(rd_data), .rd_req(rd_req)
  );

  task automatic check(input string tag);
    checks++;
    if (rd_data !== m_slot || rd_req !== m_unread) begin
      errors++;
      $display("FAIL %s: rd_data=%h rd_req=%b expected rd_data=%h rd_req=%b",
               tag, rd_data, rd_req, m_slot, m_unread);
    end
  endtask

  // Model step: what one clock edge must do given the applied inputs.
  task automatic model_edge();
    if (!enable || init_pulse) begin
      m_unread = 0;
      m_wait.delete();
    end else if (tx_mode) begin
      if (host_rd) m_unread = 0;
    end else begin
      if (host_rd) m_unread = 0;
      if (byte_done) m_wait.push_back(byte_data);
      if (!m_unread && m_wait.size() > 0) begin
        m_slot = m_wait.pop_front();
        m_unread = 1;
      end
      while (m_wait.size() > 1) void'(m_wait.pop_front());
    end
  endtask

  task automatic cyc(input bit bd, input logic [7:0] d, input bit rd,
                     input bit tx, input bit en, input bit ini, input string tag);
    byte_done = bd; byte_data = d; host_rd = rd;
    tx_mode = tx; enable = en; init_pulse = ini;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
    byte_done = 0; host_rd = 0; init_pulse = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    cyc(1, 8'hA5, 0, 0, 1, 0, "R2 single byte");
    cyc(0, 8'h00, 1, 0, 1, 0, "R3 read clears flag");
    cyc(0, 8'h00, 0, 0, 1, 0, "R3 idle");
    cyc(1, 8'h11, 0, 0, 1, 0, "R2 first of burst");
    cyc(1, 8'h22, 0, 0, 1, 0, "R4 second held");
    cyc(0, 8'h00, 0, 0, 1, 0, "R4 delayed read wait");
    cyc(1, 8'h33, 0, 0, 1, 0, "R4 held replaced");
    cyc(0, 8'h00, 1, 0, 1, 0, "R5 read moves held");
    cyc(0, 8'h00, 1, 0, 1, 0, "R3 final read");
    cyc(1, 8'h44, 0, 0, 1, 0, "R2 load");
    cyc(1, 8'h55, 1, 0, 1, 0, "R6 coincident read and byte");
    cyc(0, 8'h00, 1, 0, 1, 0, "R3 read after R6");
    cyc(1, 8'h66, 0, 1, 1, 0, "R7 tx byte ignored");
    cyc(1, 8'h67, 0, 0, 1, 0, "R2 rx after tx");
    cyc(1, 8'h68, 0, 0, 1, 0, "R4 hold before tx");
    cyc(0, 8'h00, 1, 1, 1, 0, "R7 tx read no transfer");
    cyc(0, 8'h00, 0, 1, 1, 0, "R7 tx idle still empty");
    cyc(0, 8'h00, 0, 0, 1, 0, "R10 late move in rx");
    cyc(1, 8'h77, 0, 0, 1, 0, "R4 hold before disable");
    cyc(1, 8'h78, 0, 0, 0, 0, "R8 disable clears and ignores");
    cyc(0, 8'h00, 0, 0, 1, 0, "R8 held byte dropped");
    cyc(1, 8'h81, 0, 0, 1, 0, "R2 after enable");
    cyc(1, 8'h82, 0, 0, 1, 0, "R4 hold before init");
    cyc(0, 8'h00, 0, 0, 1, 1, "R9 init clears");
    cyc(0, 8'h00, 0, 0, 1, 0, "R9 held byte dropped");
    cyc(1, 8'h90, 1, 0, 1, 0, "R2 byte with read when empty");
    for (int i = 0; i < 40; i++)
      cyc(((i % 3) != 1), 8'(i * 7 + 3), ((i % 4) == 2), ((i % 11) == 5),
          ((i % 13) != 7), ((i % 17) == 9), "R4 R5 mixed traffic");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule